// File: doc/BRIEF.md
# Oversampled Receive Word Assembler

The block recovers data from a serial line that is sampled eight times per bit. The sampling clock is locked to the local reference and not to the far end. In each core-clock cycle it takes a group of 40 raw samples, which covers five bit periods. It finds where the data transitions fall and keeps a 3-bit sample index centred in the eye. It picks one sample per bit and packs the recovered bits into a word of one, two or four 10-bit symbols.

A one-cycle strobe marks each completed word. The word output is updated in the same cycle as the strobe and is held until the next one. The strobe replaces a recovered clock, so the word clock stays locked to the local reference. When the far end runs fast, an extra bit is taken now and then, and one word period comes out a cycle short. When the far end runs slow, a bit is dropped from a group, and one word period comes out a cycle long.

The width setting is static during operation and may only change while reset is held.

Top module: `oversamp_word_asm`

## Requirements
- R1: The width select `wsel` chooses the word length: 0 gives 10 bits, 1 gives 20 bits, and 2 or 3 give 40 bits. `word[0]` holds the earliest received bit of the word. Bits of `word` above the selected length read 0.
- R2: Sample `samples[i]` is earlier in time than `samples[i+1]`. For a stream at exactly the local rate, with bit edges at sample offset 4 within each 8-sample bit, the words are consecutive chunks of the bit stream starting at the first bit after reset. The strobe then repeats every length/5 cycles.
- R3: The first group after reset release is captured at the next clock edge. The first strobe appears in the cycle after group length/5 − 1 has been captured, and no strobe appears before it.
- R4: For a stream faster than the local rate, no bit is lost or repeated. Some strobe periods are one cycle shorter than nominal, and no period is shorter than that.
- R5: For a stream slower than the local rate, no bit is lost or repeated. Some strobe periods are one cycle longer than nominal, and no period is longer than that.
- R6: A group without transitions leaves the sample index unchanged. Words stay correct across long constant runs in an offset-rate stream.
- R7: While `rst` is high, at the next edge `word_vld` is 0 and `word` is 0, and the bit count and the phase index are cleared.
- R8: With 20-bit or 40-bit words, the strobe is never high in two consecutive cycles.
- R9: `word` does not change in a cycle in which `word_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one sample group per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wsel | input | 2 | Word length select (static outside reset) |
| samples | input | 40 | Raw samples, index 0 earliest |
| word | output | 40 | Assembled word, bit 0 earliest |
| word_vld | output | 1 | One-cycle strobe for a new word |

## Verification
The assertions check the following on every cycle:
- the strobe never stays low longer than a lengthened period;
- the strobe never fires sooner than a shortened period;
- there are no back-to-back strobes for the wider words;
- the word is held between strobes, and its unused upper bits stay zero;
- reset silences the outputs.

Only the bench scenarios can show the rest. These are: the recovered bit sequence matching the transmitted one, tracking through drifts of either sign and through long runs without transitions, the exact cycle of the first strobe, and the fact that shortened and lengthened periods really occur under a rate offset.

// File: rtl/rxos_pkg.sv
package rxos_pkg;
    localparam int OSR      = 8;
    localparam int BPC      = 5;
    localparam int NSAMP    = OSR * BPC;
    localparam int SYM_W    = 10;
    localparam int MAX_SYMS = 4;
    localparam int MAX_W    = SYM_W * MAX_SYMS;
    localparam int PH_W     = $clog2(OSR);
    localparam int PICK_W   = BPC + 1;
    localparam int NB_W     = $clog2(PICK_W + 1);
    localparam int ACC_W    = MAX_W + PICK_W;
    localparam int CNT_W    = $clog2(ACC_W + 1);

    typedef enum logic [1:0] {
        SLIP_NONE = 2'd0,
        SLIP_GAIN = 2'd1,
        SLIP_LOSE = 2'd2
    } slip_e;

    typedef struct packed {
        logic [PICK_W-1:0] bits;
        logic [NB_W-1:0]   nbits;
    } pick_t;

    function automatic logic [CNT_W-1:0] word_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return CNT_W'(SYM_W);
            2'd1:    return CNT_W'(2 * SYM_W);
            default: return CNT_W'(MAX_W);
        endcase
    endfunction
endpackage

// File: rtl/rxos_phase_track.sv
module rxos_phase_track
    import rxos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSAMP-1:0] samples,
    output logic [PH_W-1:0]  ph_o,
    output slip_e            slip_o,
    output logic             prev_o
);
    localparam logic [PH_W-1:0] HALF = PH_W'(OSR / 2);
    localparam logic [PH_W-1:0] TOP  = PH_W'(OSR - 1);

    logic [PH_W-1:0] ph_q;
    logic            last_q;
    logic [NSAMP:0]  ext;
    logic            found;
    logic [PH_W-1:0] offs, target, diff;

    assign ext = {samples, last_q};

    // earliest transition in the group wins
    always_comb begin
        found = 1'b0;
        offs  = '0;
        for (int j = NSAMP - 1; j >= 0; j--) begin
            if (ext[j+1] != ext[j]) begin
                found = 1'b1;
                offs  = PH_W'(j % OSR);
            end
        end
    end

    assign target = offs + HALF;
    assign diff   = target - ph_q;

    always_comb begin
        ph_o   = ph_q;
        slip_o = SLIP_NONE;
        if (found && diff != '0 && diff != HALF) begin
            if (diff < HALF) begin
                ph_o = ph_q + 1'b1;
                if (ph_q == TOP) slip_o = SLIP_LOSE;
            end else begin
                ph_o = ph_q - 1'b1;
                if (ph_q == '0) slip_o = SLIP_GAIN;
            end
        end
    end

    assign prev_o = last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            last_q <= 1'b0;
        end else begin
            ph_q   <= ph_o;
            last_q <= samples[NSAMP-1];
        end
    end
endmodule

// File: rtl/rxos_bit_pick.sv
module rxos_bit_pick
    import rxos_pkg::*;
(
    input  logic [NSAMP-1:0] samples,
    input  logic             prev_last,
    input  logic [PH_W-1:0]  ph,
    input  slip_e            slip,
    output pick_t            pick
);
    always_comb begin
        pick = '0;
        case (slip)
            SLIP_GAIN: begin
                pick.bits[0] = prev_last;
                for (int k = 0; k < BPC; k++)
                    pick.bits[k+1] = samples[int'(ph) + OSR * k];
                pick.nbits = NB_W'(BPC + 1);
            end
            SLIP_LOSE: begin
                for (int k = 0; k < BPC - 1; k++)
                    pick.bits[k] = samples[int'(ph) + OSR * (k + 1)];
                pick.nbits = NB_W'(BPC - 1);
            end
            default: begin
                for (int k = 0; k < BPC; k++)
                    pick.bits[k] = samples[int'(ph) + OSR * k];
                pick.nbits = NB_W'(BPC);
            end
        endcase
    end
endmodule

// File: rtl/rxos_packer.sv
module rxos_packer
    import rxos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pick_t            pick,
    input  logic [CNT_W-1:0] wlen,
    output logic [MAX_W-1:0] word,
    output logic             word_vld
);
    logic [ACC_W-1:0] acc_q, acc_n, merged, mask;
    logic [CNT_W-1:0] cnt_q, cnt_n, total;
    logic [MAX_W-1:0] word_q, word_n;
    logic             vld_q, fire;

    always_comb begin
        merged = acc_q | (ACC_W'(pick.bits) << cnt_q);
        total  = cnt_q + CNT_W'(pick.nbits);
        mask   = (ACC_W'(1) << wlen) - 1'b1;
        fire   = (total >= wlen);
        word_n = MAX_W'(merged & mask);
        if (fire) begin
            acc_n = merged >> wlen;
            cnt_n = total - wlen;
        end else begin
            acc_n = merged;
            cnt_n = total;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            cnt_q  <= '0;
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            acc_q <= acc_n;
            cnt_q <= cnt_n;
            vld_q <= fire;
            if (fire) word_q <= word_n;
        end
    end

    assign word     = word_q;
    assign word_vld = vld_q;
endmodule

// File: rtl/oversamp_word_asm.sv
module oversamp_word_asm
    import rxos_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       wsel,
    input  logic [NSAMP-1:0] samples,
    output logic [MAX_W-1:0] word,
    output logic             word_vld
);
    logic [PH_W-1:0]  ph;
    slip_e            slip;
    logic             prev_last;
    pick_t            pick;
    logic [CNT_W-1:0] wlen;

    assign wlen = word_len(wsel);

    rxos_phase_track u_trk (
        .clk     (clk),
        .rst     (rst),
        .samples (samples),
        .ph_o    (ph),
        .slip_o  (slip),
        .prev_o  (prev_last)
    );

    rxos_bit_pick u_pick (
        .samples   (samples),
        .prev_last (prev_last),
        .ph        (ph),
        .slip      (slip),
        .pick      (pick)
    );

    rxos_packer u_pack (
        .clk      (clk),
        .rst      (rst),
        .pick     (pick),
        .wlen     (wlen),
        .word     (word),
        .word_vld (word_vld)
    );
endmodule

// File: rtl/rxos_chk.sv
module rxos_chk
    import rxos_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       wsel,
    input logic [MAX_W-1:0] word,
    input logic             word_vld
);
    logic [7:0] gap_q;
    int         lim;

    assign lim = int'(word_len(wsel)) / BPC;

    always_ff @(posedge clk) begin
        if (rst || word_vld) gap_q <= '0;
        else if (gap_q != 8'hff) gap_q <= gap_q + 1'b1;
    end

    // R7
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!word_vld && word == '0));

    // R8
    no_b2b_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && wsel != 2'd0) |=> !word_vld);

    // R1
    upper1_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && wsel == 2'd0) |-> word[MAX_W-1:SYM_W] == '0);

    // R1
    upper2_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (word_vld && wsel == 2'd1) |-> word[MAX_W-1:2*SYM_W] == '0);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_vld |-> $stable(word));

    // R5
    max_span_chk: assert property (@(posedge clk) disable iff (rst)
        int'(gap_q) <= lim);

    // R4
    min_span_chk: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> int'(gap_q) + 2 >= lim);
endmodule

bind oversamp_word_asm rxos_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wsel     (wsel),
    .word     (word),
    .word_vld (word_vld)
);

// File: tb/sim_oversamp_word_asm.sv
module sim_oversamp_word_asm;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wsel = 2'd2;
    logic [39:0] samples = '0;
    logic [39:0] word;
    logic        word_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [39:0] q[$];
    bit     active = 0;
    int     cyc = 0;
    int     wl = 40;
    int     mode = 0;
    longint rn = 1, rm = 1;
    bit     runs = 0;
    int     last_cyc = 0;
    bit     first_seen = 0;
    int     n_short = 0, n_long = 0;

    always #10 clk = ~clk;

    oversamp_word_asm u0 (
        .clk(clk), .rst(rst), .wsel(wsel), .samples(samples),
        .word(word), .word_vld(word_vld)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit bitval(input longint b);
        longint x;
        if (runs && (b % 96) >= 64) return 1'b0;
        x = b * 64'd2654435761;
        x = x ^ (x >> 11);
        return x[17] ^ x[5];
    endfunction

    function automatic longint bidx(input longint s);
        return ((s + 4) * rn) / (8 * rm);
    endfunction

    // monitor: scoreboard pop and strobe spacing
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (active) begin
                cyc++;
                if (word_vld) begin
                    if (q.size() == 0) begin
                        chk(0, "R2 unexpected word", word, 0);
                    end else begin
                        logic [39:0] e;
                        e = q.pop_front();
                        chk(word == e, mode == 0 ? "R2 word" : (runs ? "R6 word" : (mode == 1 ? "R4 word" : "R5 word")), word, e);
                    end
                    if (!first_seen) begin
                        chk(cyc == wl / 5, "R3 first strobe cycle", cyc, wl / 5);
                        first_seen = 1;
                    end else begin
                        int d;
                        d = cyc - last_cyc;
                        if (mode == 0) chk(d == wl / 5, "R2 period", d, wl / 5);
                        else if (mode == 1) chk(d == wl / 5 || d == wl / 5 - 1, "R4 period", d, wl / 5);
                        else chk(d == wl / 5 || d == wl / 5 + 1, "R5 period", d, wl / 5);
                        if (d < wl / 5) n_short++;
                        if (d > wl / 5) n_long++;
                    end
                    last_cyc = cyc;
                end
            end
        end
    end

    task automatic run_case(input int ws, input longint n, input longint m, input int md,
                            input int ncyc, input bit rr);
        longint nxt;
        @(negedge clk);
        rst = 1; active = 0; wsel = 2'(ws); samples = '0;
        @(posedge clk); @(posedge clk); #1;
        // R7 reset state
        chk(word_vld == 1'b0, "R7 strobe in reset", word_vld, 0);
        chk(word == '0, "R7 word in reset", word, 0);
        q.delete();
        wl = (ws == 0) ? 10 : (ws == 1) ? 20 : 40;
        rn = n; rm = m; mode = md; runs = rr;
        first_seen = 0; n_short = 0; n_long = 0; last_cyc = 0;
        nxt = 0;
        for (int g = 0; g < ncyc; g++) begin
            longint maxb;
            @(negedge clk);
            for (int i = 0; i < 40; i++) samples[i] = bitval(bidx(40 * g + i));
            if (g == 0) begin
                rst = 0; cyc = 0; active = 1;
            end
            maxb = bidx(40 * g + 39);
            while (nxt + wl - 1 <= maxb) begin
                logic [39:0] w;
                w = '0;
                for (int i = 0; i < wl; i++) w[i] = bitval(nxt + i);
                q.push_back(w);
                nxt += wl;
            end
        end
        @(posedge clk); #2;
        active = 0;
        chk(first_seen, "R3 strobe seen", first_seen, 1);
        chk(q.size() <= 1, "R2 words outstanding", q.size(), 1);
        if (md == 1) chk(n_short > 0, "R4 shortened period seen", n_short, 1);
        if (md == 2) chk(n_long > 0, "R5 lengthened period seen", n_long, 1);
        if (md != 0) chk(n_short == 0 || n_long == 0, "R4 R5 single direction", n_short, n_long);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        run_case(2, 1, 1, 0, 200, 0);       // R2 R1 40-bit nominal
        run_case(1, 1, 1, 0, 200, 0);       // R2 R1 20-bit nominal
        run_case(0, 1, 1, 0, 200, 0);       // R2 R1 10-bit nominal
        run_case(3, 1, 1, 0, 200, 0);       // R1 code 3 acts as 40 bits
        run_case(2, 257, 256, 1, 3000, 0);  // R4 fast, 40 bits
        run_case(0, 257, 256, 1, 3000, 0);  // R4 fast, 10 bits
        run_case(1, 255, 256, 2, 3000, 0);  // R5 slow, 20 bits
        run_case(0, 255, 256, 2, 3000, 0);  // R5 slow, 10 bits
        run_case(2, 257, 256, 1, 3000, 1);  // R6 runs, fast
        run_case(1, 255, 256, 2, 3000, 1);  // R6 runs, slow
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule